// File: doc/BRIEF.md
# Second-Chance Clock Victim Selector

The block tracks one reference bit for each of `NF` page frames and chooses a frame to evict when asked. Frames form a ring that a rotating hand walks through. Any access to a frame sets that frame's bit. After a request, the hand examines one frame per clock. It clears every set bit it passes and stops at the first frame whose bit is already clear. That frame becomes the victim. A single-cycle done pulse reports it, and the hand then rests on the next frame in the ring.

If every bit is set, the hand makes one full lap and clears all of them. It then returns to the frame where it started and takes that frame, even if an access has set its bit again during the lap. This limits a search to `NF+1` examined frames. Accesses are accepted in every cycle, including during a search. The victim's own bit is set when it is chosen, because the frame is about to be refilled. A second request that arrives during a search is dropped.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset, no done pulse is asserted, all reference bits are clear, and the hand points to frame 0. The first request therefore selects frame 0.
- R2: When `acc_valid` is high at a clock edge, the reference bit of frame `acc_idx` is set at that edge.
- R3: During a search the hand examines exactly one frame per clock. A frame whose bit is set has its bit cleared and is skipped.
- R4: The first examined frame whose bit is clear is the victim. `done` is high for exactly one cycle, in the cycle after that frame was examined, and `victim` carries its index in that cycle.
- R5: After a selection the hand points to the frame after the victim, wrapping from `NF-1` to 0. The next search starts there.
- R6: If every examined frame has its bit set, the search selects the frame it started from after `NF+1` examined frames. `done` rises `NF+1` cycles after the edge that accepted the request.
- R7: An access to the frame under the hand, in the cycle that frame is examined, leaves that frame's bit set.
- R8: A request that arrives while a search is in progress is ignored and produces no extra done pulse.
- R9: The victim's reference bit is set at the selection edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to frame `acc_idx` occurs in this cycle |
| acc_idx | input | $clog2(NF) | Frame index of the access |
| req | input | 1 | Request for a victim; accepted only when no search is running |
| done | output | 1 | Single-cycle pulse: `victim` is valid |
| victim | output | $clog2(NF) | Index of the selected frame |

## Verification
An access and the scan's clearing of a bit can target the same frame in the same cycle. A second request can also arrive while a search is still running. The bench provokes the first collision by accessing the frame under the hand on the first scan cycle. It then sets every other bit and runs another search: with a correct design that search makes a full lap, and if the access had lost to the clear, the search would stop early at that frame. For the second collision, the bench raises a request inside a running search and checks that no further done pulse follows. A behavioural model, stepped on every clock, judges `done` and `victim` throughout the run.

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int NF = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [$clog2(NF)-1:0] acc_idx,
  input  logic                  req,
  output logic                  done,
  output logic [$clog2(NF)-1:0] victim
);
  localparam int IW = $clog2(NF);
  localparam int CW = $clog2(NF + 1);

  logic [NF-1:0] ref_q, ref_d;
  logic [IW-1:0] hand_q, victim_q;
  logic [CW-1:0] laps_q;
  logic          busy_q, done_q;

  wire [IW-1:0] hand_nx = (hand_q == IW'(NF - 1)) ? '0 : hand_q + 1'b1;
  wire          lap_full = (laps_q == CW'(NF));
  wire          pick = busy_q && (!ref_q[hand_q] || lap_full);

  always_comb begin
    ref_d = ref_q;
    if (busy_q) ref_d[hand_q] = pick;
    if (acc_valid) ref_d[acc_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      hand_q   <= '0;
      laps_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      ref_q  <= ref_d;
      done_q <= pick;
      if (busy_q) begin
        hand_q <= hand_nx;
        if (pick) begin
          busy_q   <= 1'b0;
          victim_q <= hand_q;
        end else begin
          laps_q <= laps_q + 1'b1;
        end
      end else if (req) begin
        busy_q <= 1'b1;
        laps_q <= '0;
      end
    end
  end

  assign done   = done_q;
  assign victim = victim_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_VICTIM_MARKED: assert property (@(posedge clk) disable iff (!rst_n) done |-> ref_q[victim]); // R9
  AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> hand_q == ((victim == IW'(NF - 1)) ? '0 : victim + 1'b1)); // R5
  AST_LAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> laps_q <= CW'(NF)); // R6
  AST_ACCESS_SETS: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> ref_q[$past(acc_idx)]); // R2
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pick) |=> (busy_q && !done)); // R8
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> hand_q == (($past(hand_q) == IW'(NF - 1)) ? '0 : $past(hand_q) + 1'b1)); // R3
endmodule

// File: tb/clock_victim_picker_bench.sv
module clock_victim_picker_bench;
  localparam int NF = 8;
  localparam int IW = $clog2(NF);
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic req = 1'b0;
  logic done;
  logic [IW-1:0] victim;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  bit m_ref[NF];
  int m_hand = 0, m_laps = 0, m_vict = 0;
  bit m_busy = 0, m_done = 0;

  clock_victim_picker #(.NF(NF)) u_clock_victim_picker (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .req(req), .done(done), .victim(victim)
  );

  always #(TCLK / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit nd = 0;
    if (m_busy) begin
      if (!m_ref[m_hand] || m_laps == NF) begin
        m_vict = m_hand;
        m_ref[m_hand] = 1;
        m_hand = (m_hand + 1) % NF;
        m_busy = 0;
        nd = 1;
      end else begin
        m_ref[m_hand] = 0;
        m_hand = (m_hand + 1) % NF;
        m_laps++;
      end
    end else if (req) begin
      m_busy = 1;
      m_laps = 0;
    end
    if (acc_valid) m_ref[int'(acc_idx)] = 1;
    m_done = nd;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cycles++;
    check(done == m_done, "R4 done vs model", int'(done), int'(m_done));
    if (m_done) check(int'(victim) == m_vict, "R4 victim vs model", int'(victim), m_vict);
    acc_valid = 1'b0;
    req = 1'b0;
  endtask

  task automatic touch(input int f);
    acc_valid = 1'b1;
    acc_idx = IW'(f);
    tick();
  endtask

  task automatic run_req(input int exp_v, input int exp_lat, input string tag);
    int lat = 0;
    bit seen = 0;
    req = 1'b1;
    tick();
    while (!seen && lat < 40) begin
      tick();
      lat++;
      if (done) seen = 1;
    end
    check(seen && int'(victim) == exp_v, {tag, " victim"}, int'(victim), exp_v);
    check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
  endtask

  initial begin
    for (int i = 0; i < NF; i++) m_ref[i] = 0;
    @(negedge clk);
    check(done == 1'b0, "R1 done low in reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check(done == 1'b0, "R1 done low after reset", int'(done), 0);
    run_req(0, 1, "R1 first pick");
    touch(1);
    touch(2);
    run_req(3, 3, "R2 R3 skip set frames");
    for (int f = 0; f < NF; f++) touch(f);
    run_req(4, NF + 1, "R6 full lap");
    run_req(5, 1, "R5 R9 hand after victim");
    touch(6);
    touch(7);
    req = 1'b1;
    tick();
    acc_valid = 1'b1;
    acc_idx = IW'(6);
    tick();
    tick();
    tick();
    check(done && int'(victim) == 0, "R7 pick after protected frame", int'(victim), 0);
    touch(1);
    touch(2);
    touch(3);
    touch(7);
    run_req(1, NF + 1, "R7 protected bit survived");
    req = 1'b1;
    tick();
    req = 1'b1;
    tick();
    check(done && int'(victim) == 2, "R8 pick during repeat request", int'(victim), 2);
    for (int k = 0; k < NF + 4; k++) begin
      tick();
      check(done == 1'b0, "R8 no extra done", int'(done), 0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule